// File: doc/BRIEF.md
# Signed-Digit Digit-Product Unit

This block multiplies two radix-2^H digits. Each digit carries H ordinary bits (posibits) at weights 2^0 to 2^(H-1), plus one negative-weight bit (a negabit) at weight 1. A negabit is held in inverted logic: a stored 1 is worth 0 and a stored 0 is worth -1. A digit's value therefore lies between -1 and 2^H - 1. The exact product comes back as a two-digit redundant number. Both the low digit and the high digit have the same form as an input digit, and the high digit is scaled by 2^H. The result is never converted to signed binary.

Bit products come from polarity-aware gates. An AND gate joins two posibits. An AND gate with an inverted negabit input and an inverted output joins a posibit and a negabit. A NOR gate joins two negabits. The bit products are then reduced in the stored domain by rows of full adders. A final layer of half adders and modified half adders brings in a fixed correction. In the modified cell the missing input counts as a zero-valued negabit, so it holds a stored 1. A short ripple stage finishes the sum.

The low digit's negabit is the lowest posibit-times-negabit product, passed through unchanged. The high digit's negabit takes the parity of the high half of the sum. The unit is purely combinational and takes H >= 2 as its only parameter. It is meant to be replicated in a larger multiplier that places and accumulates digit products.

Top module: `sd_digit_mul`

## Requirements
- R1: For every encoding of the two inputs, lo_pos + (lo_neg - 1) + 2^H * (hi_pos + (hi_neg - 1)) equals (a_pos + a_neg - 1) * (b_pos + b_neg - 1). The posibit fields are read as unsigned integers and the negabits as stored 0/1.
- R2: With H = 3, a_pos = 3, a_neg = 1, b_pos = 5, b_neg = 1 (values 3 and 5), the output is worth 15.
- R3: lo_neg is stored 0 exactly when a_pos bit 0 is 1 and b_neg is stored 0; otherwise it is stored 1.
- R4: hi_pos bit 0 is always 0.
- R5: The output depends only on the present inputs and settles within the clock period in which the inputs change; there is no register.
- R6: Two digits both worth -1 (posibits 0, negabits stored 0) give a product worth +1.
- R7: A digit worth 2^H - 1 times a digit worth -1 gives -(2^H - 1), whichever operand is negative.
- R8: Two digits worth 2^H - 1 (all posibits 1, negabits stored 1) give (2^H - 1)^2.
- R9: An operand worth 0, whether reached with a negabit stored 1 and posibits 0 or with posibits 1 and negabit stored 0, gives a product worth 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_pos | input | H | Posibits of operand A, bit i at weight 2^i |
| a_neg | input | 1 | Negabit of operand A at weight 1, stored 1 = 0, stored 0 = -1 |
| b_pos | input | H | Posibits of operand B |
| b_neg | input | 1 | Negabit of operand B, same encoding |
| lo_pos | output | H | Posibits of the low result digit |
| lo_neg | output | 1 | Negabit of the low result digit, weight 1 |
| hi_pos | output | H | Posibits of the high result digit, scaled by 2^H |
| hi_neg | output | 1 | Negabit of the high result digit, weight 2^H |

## Verification
Column 0 is the one place where two separate mechanisms overlap in the same evaluation. When both negabits are at -1 and A's lowest posibit is set, the negabit-by-negabit posibit enters the adder array in that column while the low negabit bypasses the array. The fixed correction is also active in column 0. The bench provokes this by sweeping every encoding pair for H = 3 and H = 4 and adding directed corner vectors. Each result is judged two ways: the decoded two-digit value is compared with the integer product, and the bypassed negabit is compared with its gate rule in the same sample.

// File: rtl/sd_digit_pkg.sv
package sd_digit_pkg;

  // Polarity-aware bit products (negabits carried in inverted logic)
  function automatic logic bp_pp(input logic x, input logic y);
    return x & y;
  endfunction

  function automatic logic bp_pn(input logic x, input logic n_st);
    return ~(x & ~n_st);
  endfunction

  function automatic logic bp_nn(input logic n1_st, input logic n2_st);
    return ~(n1_st | n2_st);
  endfunction

  // Stored-domain counter cells
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_cry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic ha_sum(input logic a, input logic b);
    return a ^ b;
  endfunction

  function automatic logic ha_cry(input logic a, input logic b);
    return a & b;
  endfunction

  // Modified half adder: the absent input is a zero-valued negabit (stored 1)
  function automatic logic hap_sum(input logic a, input logic b);
    return ~(a ^ b);
  endfunction

  function automatic logic hap_cry(input logic a, input logic b);
    return a | b;
  endfunction

  // Integer worth of a digit field plus its inverted-logic negabit
  function automatic int digit_value(input int pos_val, input logic n_st);
    return pos_val + int'(n_st) - 1;
  endfunction

endpackage

// File: rtl/sd_bitprod.sv
module sd_bitprod
  import sd_digit_pkg::*;
#(
  parameter int H = 4
) (
  input  logic [H-1:0]                 a_pos,
  input  logic                         a_neg,
  input  logic [H-1:0]                 b_pos,
  input  logic                         b_neg,
  output logic [H+1:0][2*H-1:0]        rows,
  output logic                         lo_neg
);
  localparam int W2 = 2 * H;
  localparam int NR = H + 2;
  localparam int RA = NR - 2;  // row holding A-posibit x B-negabit products
  localparam int RB = NR - 1;  // row holding B-posibit x A-negabit products

  // posibit x posibit matrix, row j shifted by j
  for (genvar j = 0; j < H; j++) begin : g_prow
    for (genvar c = 0; c < W2; c++) begin : g_col
      if (c >= j && c < j + H) begin : g_on
        assign rows[j][c] = bp_pp(a_pos[c-j], b_pos[j]);
      end else begin : g_off
        assign rows[j][c] = 1'b0;
      end
    end
  end

  // A-side negabit row; column 0 is reused for the negabit x negabit posibit
  for (genvar c = 0; c < W2; c++) begin : g_arow
    if (c == 0) begin : g_nn
      assign rows[RA][c] = bp_nn(a_neg, b_neg);
    end else if (c < H) begin : g_pn
      assign rows[RA][c] = bp_pn(a_pos[c], b_neg);
    end else begin : g_zero
      assign rows[RA][c] = 1'b0;
    end
  end

  // B-side negabit row
  for (genvar c = 0; c < W2; c++) begin : g_brow
    if (c < H) begin : g_pn
      assign rows[RB][c] = bp_pn(b_pos[c], a_neg);
    end else begin : g_zero
      assign rows[RB][c] = 1'b0;
    end
  end

  // lowest A-posibit x B-negabit product bypasses the array
  assign lo_neg = bp_pn(a_pos[0], b_neg);

  always_comb begin : chk_bitprod
    int pos_ones;
    int a_minus;
    int b_minus;
    pos_ones = 0;
    for (int j = 0; j < H; j++) pos_ones += $countones(rows[j]);
    a_minus = (H - 1) - $countones(rows[RA][H-1:1]) + (lo_neg ? 0 : 1);
    b_minus = H - $countones(rows[RB][H-1:0]);
    // R1: posibit matrix population matches the operand populations
    a_r1_pos_matrix: assert (pos_ones == $countones(a_pos) * $countones(b_pos))
      else $error("posibit matrix population mismatch");
    // R3: a -1 negabit product appears only for set posibits against a -1 negabit
    a_r3_neg_rows: assert (a_minus == (b_neg ? 0 : $countones(a_pos)) &&
                           b_minus == (a_neg ? 0 : $countones(b_pos)))
      else $error("negabit product count mismatch");
  end

endmodule

// File: rtl/sd_compress.sv
module sd_compress
  import sd_digit_pkg::*;
#(
  parameter int H = 4
) (
  input  logic [H+1:0][2*H-1:0] rows,
  output logic [2*H-1:0]        total
);
  localparam int W2 = 2 * H;
  localparam int NR = H + 2;
  localparam int NS = NR - 1;
  // Correction 2^(2H) - (2^H - 3), folded in through modified half adders
  localparam logic [W2-1:0] CORR = W2'(3) - W2'(1 << H);

  logic [NS-1:0][W2-1:0] s_st;
  logic [NS-1:0][W2-1:0] c_st;

  assign s_st[0] = rows[0];
  assign c_st[0] = rows[1];

  // carry-save rows of full adders, one per remaining bit-product row
  for (genvar k = 1; k < NS; k++) begin : g_csa
    assign c_st[k][0] = 1'b0;
    for (genvar i = 0; i < W2; i++) begin : g_bit
      assign s_st[k][i] = fa_sum(s_st[k-1][i], c_st[k-1][i], rows[k+1][i]);
      if (i < W2 - 1) begin : g_cy
        assign c_st[k][i+1] = fa_cry(s_st[k-1][i], c_st[k-1][i], rows[k+1][i]);
      end
    end
  end

  // correction layer: the constant picks the cell variant per column
  logic [W2-1:0] s_cr;
  logic [W2-1:0] c_cr;
  assign c_cr[0] = 1'b0;
  for (genvar i = 0; i < W2; i++) begin : g_corr
    if (CORR[i]) begin : g_hap
      assign s_cr[i] = hap_sum(s_st[NS-1][i], c_st[NS-1][i]);
      if (i < W2 - 1) begin : g_cy
        assign c_cr[i+1] = hap_cry(s_st[NS-1][i], c_st[NS-1][i]);
      end
    end else begin : g_ha
      assign s_cr[i] = ha_sum(s_st[NS-1][i], c_st[NS-1][i]);
      if (i < W2 - 1) begin : g_cy
        assign c_cr[i+1] = ha_cry(s_st[NS-1][i], c_st[NS-1][i]);
      end
    end
  end

  // final ripple, carry out of the top column is discarded
  logic [W2-2:0] rc;
  assign total[0] = ha_sum(s_cr[0], c_cr[0]);
  assign rc[0]    = ha_cry(s_cr[0], c_cr[0]);
  for (genvar i = 1; i < W2; i++) begin : g_rip
    assign total[i] = fa_sum(s_cr[i], c_cr[i], rc[i-1]);
    if (i < W2 - 1) begin : g_cy
      assign rc[i] = fa_cry(s_cr[i], c_cr[i], rc[i-1]);
    end
  end

  always_comb begin : chk_compress
    // R1: the corrected stored sum is never zero for any legal product
    a_r1_sum_nonzero: assert (total != '0)
      else $error("corrected sum out of range");
  end

endmodule

// File: rtl/sd_digit_split.sv
module sd_digit_split #(
  parameter int H = 4
) (
  input  logic [2*H-1:0] total,
  output logic [H-1:0]   lo_pos,
  output logic [H-1:0]   hi_pos,
  output logic           hi_neg
);
  localparam int W2 = 2 * H;

  // low half stays as posibits; high half q is written as even posibits plus
  // its parity in the negabit slot, so hi_pos + hi_neg == q
  assign lo_pos = total[H-1:0];
  assign hi_pos = {total[W2-1:H+1], 1'b0};
  assign hi_neg = total[H];

endmodule

// File: rtl/sd_digit_mul.sv
module sd_digit_mul
  import sd_digit_pkg::*;
#(
  parameter int H = 4
) (
  input  logic [H-1:0] a_pos,
  input  logic         a_neg,
  input  logic [H-1:0] b_pos,
  input  logic         b_neg,
  output logic [H-1:0] lo_pos,
  output logic         lo_neg,
  output logic [H-1:0] hi_pos,
  output logic         hi_neg
);
  localparam int W2 = 2 * H;
  localparam int NR = H + 2;

  logic [NR-1:0][W2-1:0] pp_rows;
  logic [W2-1:0]         corr_sum;

  sd_bitprod #(.H(H)) u_bitprod (
    .a_pos  (a_pos),
    .a_neg  (a_neg),
    .b_pos  (b_pos),
    .b_neg  (b_neg),
    .rows   (pp_rows),
    .lo_neg (lo_neg)
  );

  sd_compress #(.H(H)) u_compress (
    .rows  (pp_rows),
    .total (corr_sum)
  );

  sd_digit_split #(.H(H)) u_split (
    .total  (corr_sum),
    .lo_pos (lo_pos),
    .hi_pos (hi_pos),
    .hi_neg (hi_neg)
  );

  always_comb begin : chk_top
    int va;
    int vb;
    int vout;
    va   = digit_value(int'(a_pos), a_neg);
    vb   = digit_value(int'(b_pos), b_neg);
    vout = digit_value(int'(lo_pos), lo_neg) +
           digit_value(int'(hi_pos), hi_neg) * (1 << H);
    // R1: decoded two-digit result equals the integer product
    a_r1_value_exact: assert (vout == va * vb)
      else $error("two-digit result differs from product");
  end

endmodule

// File: tb/sd_digit_mul_tb_top.sv
module sd_digit_mul_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [3:0] a4_pos = '0, b4_pos = '0, lo4_pos, hi4_pos;
  logic       a4_neg = 1'b0, b4_neg = 1'b0, lo4_neg, hi4_neg;
  logic [2:0] a3_pos = '0, b3_pos = '0, lo3_pos, hi3_pos;
  logic       a3_neg = 1'b0, b3_neg = 1'b0, lo3_neg, hi3_neg;

  sd_digit_mul #(.H(4)) dut_i (
    .a_pos(a4_pos), .a_neg(a4_neg), .b_pos(b4_pos), .b_neg(b4_neg),
    .lo_pos(lo4_pos), .lo_neg(lo4_neg), .hi_pos(hi4_pos), .hi_neg(hi4_neg)
  );

  sd_digit_mul #(.H(3)) dut_h3_i (
    .a_pos(a3_pos), .a_neg(a3_neg), .b_pos(b3_pos), .b_neg(b3_neg),
    .lo_pos(lo3_pos), .lo_neg(lo3_neg), .hi_pos(hi3_pos), .hi_neg(hi3_neg)
  );

  typedef struct {
    int    hsel;
    int    pa;
    int    na;
    int    pb;
    int    nb;
    string tag;
  } vec_t;

  vec_t sb_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  // driver: apply one encoding pair and queue what the monitor must see
  task automatic apply(input int hsel, input int pa, input int na,
                       input int pb, input int nb, input string tag);
    vec_t it;
    @(posedge clk);
    #1;
    if (hsel == 4) begin
      a4_pos = 4'(pa); a4_neg = na[0]; b4_pos = 4'(pb); b4_neg = nb[0];
    end else begin
      a3_pos = 3'(pa); a3_neg = na[0]; b3_pos = 3'(pb); b3_neg = nb[0];
    end
    it.hsel = hsel; it.pa = pa; it.na = na; it.pb = pb; it.nb = nb; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: pop and compare half a period after the inputs moved
  always @(negedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      vec_t it;
      int lp, ln, hp, hn, act, exp, exp_ln;
      it = sb_q.pop_front();
      if (it.hsel == 4) begin
        lp = int'(lo4_pos); ln = int'(lo4_neg); hp = int'(hi4_pos); hn = int'(hi4_neg);
      end else begin
        lp = int'(lo3_pos); ln = int'(lo3_neg); hp = int'(hi3_pos); hn = int'(hi3_neg);
      end
      act = (lp + ln - 1) + (hp + hn - 1) * (1 << it.hsel);
      exp = (it.pa + it.na - 1) * (it.pb + it.nb - 1);
      check({it.tag, "/R5 product value"}, act, exp);
      exp_ln = ((it.pa % 2) == 1 && it.nb == 0) ? 0 : 1;
      check("R3 low negabit", ln, exp_ln);
      check("R4 high posibit 0", hp % 2, 0);
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R5 watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin : main
    // reset phase: all inputs zero means both operands worth -1
    repeat (2) @(negedge clk);
    check("R6 during reset", (int'(lo4_pos) + int'(lo4_neg) - 1) +
          (int'(hi4_pos) + int'(hi4_neg) - 1) * 16, 1);
    @(posedge clk);
    #1 rst = 1'b0;

    apply(3, 3, 1, 5, 1, "R2");          // 3 x 5 = 15
    apply(4, 0, 0, 0, 0, "R6");          // -1 x -1
    apply(3, 0, 0, 0, 0, "R6");
    apply(4, 15, 1, 0, 0, "R7");         // 15 x -1
    apply(4, 0, 0, 15, 1, "R7");         // -1 x 15
    apply(3, 7, 1, 0, 0, "R7");
    apply(4, 15, 1, 15, 1, "R8");        // 225
    apply(3, 7, 1, 7, 1, "R8");          // 49
    apply(4, 0, 1, 9, 0, "R9");          // 0 x 8
    apply(4, 6, 0, 1, 0, "R9");          // 5 x 0 with posibits 1, negabit -1
    apply(3, 1, 0, 6, 1, "R9");

    // exhaustive sweeps: encoding e = {posibits, negabit}
    for (int ea = 0; ea < 16; ea++) begin
      for (int eb = 0; eb < 16; eb++) begin
        apply(3, ea >> 1, ea % 2, eb >> 1, eb % 2, "R1");
      end
    end
    for (int ea = 0; ea < 32; ea++) begin
      for (int eb = 0; eb < 32; eb++) begin
        apply(4, ea >> 1, ea % 2, eb >> 1, eb % 2, "R1");
      end
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    report();
    $finish;
  end

endmodule